// File: doc/BRIEF.md
# PWM Event Flag and Interrupt Combiner

This block turns the raw state of a six-channel PWM timer into sticky event flags and a single interrupt line. Each channel presents its counter value, its counting direction, its period value and its compare value. The block notices when a counter arrives at zero, arrives at its period, or arrives at its compare value. A compare arrival sets one of two flags, depending on whether the counter is counting up or down at that moment. Rising and falling capture strobes from the capture edge detectors are latched as flags of a second status word.

Every flag stays set until software writes a 1 to its bit. Flags ANDed with their enable bits drive one registered, level-sensitive PWM interrupt. Capture flags share this line. A brake request is carried to a separate brake interrupt output and never mixes with the PWM line. The counters, the waveform generator, the capture edge detectors and the brake logic are not part of this block.

Top module: `pwm_irq_hub`

## Requirements
- R1: After reset, both status words read 0, all enables are 0, and `pwm_irq` and `brk_irq` are 0.
- R2: Bit n (0..5) of `stat_rd` is set on the clock edge where channel n's counter first equals 0.
- R3: Bit 8+n of `stat_rd` is set on the edge where channel n's counter first equals its period value.
- R4: Bit 16+n of `stat_rd` is set when channel n's counter first equals its compare value while `cnt_up[n]` is 1.
- R5: Bit 24+n of `stat_rd` is set when channel n's counter first equals its compare value while `cnt_up[n]` is 0. The up-compare flag is left unchanged in this case.
- R6: A condition that stays true over several cycles sets its flag only once per arrival. If the flag is cleared while the condition holds, it stays clear.
- R7: A write with `stat_clr_we` clears every status bit whose `stat_clr_data` bit is 1 and leaves the other bits alone. `cap_clr_we`/`cap_clr_data` act the same way on `cap_rd`. If an event arrives in the same cycle as a clear of its bit, the bit ends up set.
- R8: A cycle with `cap_rise[n]` high sets bit n of `cap_rd`. A cycle with `cap_fall[n]` high sets bit 8+n.
- R9: `pwm_irq` is a register. One cycle after the status and enable registers hold any bit set in both, it goes high, and it stays high for as long as that is true. A set flag whose enable bit is 0 does not raise the line.
- R10: Capture flags gated by the capture enable register drive the same `pwm_irq` output.
- R11: `brk_irq` equals `brk_req` delayed by one clock and is independent of every flag and enable.
- R12: Status and enable bits outside the lanes listed above (bits 6-7, 14-15, 22-23, 30-31 of the main word; bits 6-7, 14-15 of the capture word) always read 0, and writing enables there has no effect on `pwm_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | 96 | Counter values, channel n in bits 16n+15:16n |
| cnt_up | input | 6 | Counting direction per channel, 1 = up |
| per_val | input | 96 | Period values, same packing as cnt_val |
| cmp_val | input | 96 | Compare values, same packing as cnt_val |
| cap_rise | input | 6 | Rising capture event strobes |
| cap_fall | input | 6 | Falling capture event strobes |
| brk_req | input | 1 | Brake request from the brake logic |
| stat_clr_we | input | 1 | Write-1-to-clear strobe for the main status word |
| stat_clr_data | input | 32 | Bits to clear in the main status word |
| cap_clr_we | input | 1 | Write-1-to-clear strobe for the capture status word |
| cap_clr_data | input | 16 | Bits to clear in the capture status word |
| stat_en_we | input | 1 | Load strobe for the main enable register |
| stat_en_data | input | 32 | New main enable value |
| cap_en_we | input | 1 | Load strobe for the capture enable register |
| cap_en_data | input | 16 | New capture enable value |
| stat_rd | output | 32 | Main status word |
| cap_rd | output | 16 | Capture status word |
| pwm_irq | output | 1 | Combined PWM and capture interrupt, level |
| brk_irq | output | 1 | Brake interrupt |

## Verification
A wrong edge-qualification register in one detector shows up on `stat_rd` on the very next edge, as a flag that fails to set or one that comes back after a clear while a counter sits on a value. A flag bank that loses or invents a bit appears at once on the status read. Its effect on `pwm_irq` follows one cycle later, as long as the bit is enabled. If direction steering is broken, an up match sets a down flag on the edge of the match. The bench runs random counters that dwell on matching values, together with clears that collide with events, so these faults surface within a few cycles.

// File: rtl/pwm_irq_pkg.sv
package pwm_irq_pkg;

   localparam int STAT_W = 32;
   localparam int CAP_W  = 16;
   localparam int LANE_W = 8;

   typedef enum logic [1:0] {
      EV_ZERO   = 2'd0,
      EV_PERIOD = 2'd1,
      EV_CMP_UP = 2'd2,
      EV_CMP_DN = 2'd3
   } evt_kind_e;

   localparam int NUM_KINDS = 4;

   function automatic logic [STAT_W-1:0] lane_mask(input int nch, input int lanes);
      logic [STAT_W-1:0] m;
      m = '0;
      for (int k = 0; k < lanes; k++) begin
         for (int n = 0; n < nch; n++) begin
            m[k*LANE_W + n] = 1'b1;
         end
      end
      return m;
   endfunction

endpackage

// File: rtl/pwm_evt_detect.sv
module pwm_evt_detect
   import pwm_irq_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CW-1:0]        cnt,
   input  logic                 dir_up,
   input  logic [CW-1:0]        per,
   input  logic [CW-1:0]        cmp,
   output logic [NUM_KINDS-1:0] evt
);

   initial begin
      assert (CW >= 2) else $error("pwm_evt_detect: CW must be at least 2");
   end

   logic [NUM_KINDS-1:0] cond;
   logic [NUM_KINDS-1:0] prev_q;
   logic                 at_cmp;

   assign at_cmp = (cnt == cmp);

   always_comb begin
      cond            = '0;
      cond[EV_ZERO]   = (cnt == '0);
      cond[EV_PERIOD] = (cnt == per);
      cond[EV_CMP_UP] = at_cmp &  dir_up;
      cond[EV_CMP_DN] = at_cmp & ~dir_up;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cond;
   end

   assign evt = cond & ~prev_q;

   // R6
   once_per_arrival_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((evt & $past(evt)) == '0));

   // R5
   dir_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt[EV_CMP_UP] && evt[EV_CMP_DN]));

endmodule

// File: rtl/pwm_flag_bank.sv
module pwm_flag_bank #(
   parameter int         W     = 32,
   parameter logic [W-1:0] VALID = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_we,
   input  logic [W-1:0] clr_data,
   output logic [W-1:0] flags_o
);

   initial begin
      assert (W >= 1) else $error("pwm_flag_bank: W must be positive");
   end

   logic [W-1:0] flags_q;
   logic [W-1:0] clr_mask;

   assign clr_mask = clr_we ? clr_data : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= ((flags_q & ~clr_mask) | set_i) & VALID;
   end

   assign flags_o = flags_q;

   // R7
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> (($past(flags_q) & ~flags_q) == '0));

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_i & VALID) != '0) |=> ((flags_q & $past(set_i & VALID)) == $past(set_i & VALID)));

   // R12
   unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q & ~VALID) == '0);

endmodule

// File: rtl/pwm_irq_hub.sv
module pwm_irq_hub
   import pwm_irq_pkg::*;
#(
   parameter int NCH = 6,
   parameter int CW  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH*CW-1:0] cnt_val,
   input  logic [NCH-1:0]    cnt_up,
   input  logic [NCH*CW-1:0] per_val,
   input  logic [NCH*CW-1:0] cmp_val,
   input  logic [NCH-1:0]    cap_rise,
   input  logic [NCH-1:0]    cap_fall,
   input  logic              brk_req,
   input  logic              stat_clr_we,
   input  logic [STAT_W-1:0] stat_clr_data,
   input  logic              cap_clr_we,
   input  logic [CAP_W-1:0]  cap_clr_data,
   input  logic              stat_en_we,
   input  logic [STAT_W-1:0] stat_en_data,
   input  logic              cap_en_we,
   input  logic [CAP_W-1:0]  cap_en_data,
   output logic [STAT_W-1:0] stat_rd,
   output logic [CAP_W-1:0]  cap_rd,
   output logic              pwm_irq,
   output logic              brk_irq
);

   localparam logic [STAT_W-1:0] STAT_VALID = lane_mask(NCH, NUM_KINDS);
   localparam logic [STAT_W-1:0] CAP_VALID_W = lane_mask(NCH, 2);
   localparam logic [CAP_W-1:0]  CAP_VALID  = CAP_VALID_W[CAP_W-1:0];

   initial begin
      assert (NCH >= 1 && NCH <= LANE_W) else $error("pwm_irq_hub: NCH must be 1..8");
      assert (CW >= 2) else $error("pwm_irq_hub: CW must be at least 2");
   end

   logic [STAT_W-1:0] stat_set;
   logic [CAP_W-1:0]  cap_set;
   logic [STAT_W-1:0] stat_flags;
   logic [CAP_W-1:0]  cap_flags;
   logic [STAT_W-1:0] stat_en_q;
   logic [CAP_W-1:0]  cap_en_q;
   logic              irq_q;
   logic              brk_q;

   generate
      for (genvar n = 0; n < NCH; n++) begin : g_ch
         logic [NUM_KINDS-1:0] ch_evt;

         pwm_evt_detect #(.CW(CW)) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt    (cnt_val[n*CW +: CW]),
            .dir_up (cnt_up[n]),
            .per    (per_val[n*CW +: CW]),
            .cmp    (cmp_val[n*CW +: CW]),
            .evt    (ch_evt)
         );

         for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
            assign stat_set[k*LANE_W + n] = ch_evt[k];
         end

         assign cap_set[n]          = cap_rise[n];
         assign cap_set[LANE_W + n] = cap_fall[n];
      end

      for (genvar b = 0; b < STAT_W; b++) begin : g_stat_fill
         if (!STAT_VALID[b]) begin : g_zero
            assign stat_set[b] = 1'b0;
         end
      end

      for (genvar b = 0; b < CAP_W; b++) begin : g_cap_fill
         if (!CAP_VALID[b]) begin : g_zero
            assign cap_set[b] = 1'b0;
         end
      end
   endgenerate

   pwm_flag_bank #(.W(STAT_W), .VALID(STAT_VALID)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (stat_set),
      .clr_we   (stat_clr_we),
      .clr_data (stat_clr_data),
      .flags_o  (stat_flags)
   );

   pwm_flag_bank #(.W(CAP_W), .VALID(CAP_VALID)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (cap_set),
      .clr_we   (cap_clr_we),
      .clr_data (cap_clr_data),
      .flags_o  (cap_flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_en_q <= '0;
         cap_en_q  <= '0;
         irq_q     <= 1'b0;
         brk_q     <= 1'b0;
      end else begin
         if (stat_en_we) stat_en_q <= stat_en_data & STAT_VALID;
         if (cap_en_we)  cap_en_q  <= cap_en_data & CAP_VALID;
         irq_q <= (|(stat_flags & stat_en_q)) | (|(cap_flags & cap_en_q));
         brk_q <= brk_req;
      end
   end

   assign stat_rd = stat_flags;
   assign cap_rd  = cap_flags;
   assign pwm_irq = irq_q;
   assign brk_irq = brk_q;

   // R9
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_irq |-> ($past(stat_rd) != '0 || $past(cap_rd) != '0));

   // R11
   brk_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (brk_irq == $past(brk_req)));

endmodule

// File: tb/sim_pwm_irq_hub.sv
module sim_pwm_irq_hub;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 6;
   localparam int CW  = 16;
   localparam logic [31:0] SVALID = 32'h3F3F3F3F;
   localparam logic [15:0] CVALID = 16'h3F3F;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH*CW-1:0] cnt_val = '0;
   logic [NCH-1:0]    cnt_up = '0;
   logic [NCH*CW-1:0] per_val = '0;
   logic [NCH*CW-1:0] cmp_val = '0;
   logic [NCH-1:0]    cap_rise = '0;
   logic [NCH-1:0]    cap_fall = '0;
   logic              brk_req = 1'b0;
   logic              stat_clr_we = 1'b0;
   logic [31:0]       stat_clr_data = '0;
   logic              cap_clr_we = 1'b0;
   logic [15:0]       cap_clr_data = '0;
   logic              stat_en_we = 1'b0;
   logic [31:0]       stat_en_data = '0;
   logic              cap_en_we = 1'b0;
   logic [15:0]       cap_en_data = '0;
   logic [31:0]       stat_rd;
   logic [15:0]       cap_rd;
   logic              pwm_irq;
   logic              brk_irq;

   int checks = 0;
   int failures = 0;

   logic [31:0] m_stat = '0;
   logic [15:0] m_cap = '0;
   logic [31:0] m_sen = '0;
   logic [15:0] m_cen = '0;
   logic [3:0]  m_prev [NCH];
   logic        m_irq = 1'b0;
   logic        m_brk = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_irq_hub #(.NCH(NCH), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_up(cnt_up),
      .per_val(per_val), .cmp_val(cmp_val), .cap_rise(cap_rise), .cap_fall(cap_fall),
      .brk_req(brk_req), .stat_clr_we(stat_clr_we), .stat_clr_data(stat_clr_data),
      .cap_clr_we(cap_clr_we), .cap_clr_data(cap_clr_data), .stat_en_we(stat_en_we),
      .stat_en_data(stat_en_data), .cap_en_we(cap_en_we), .cap_en_data(cap_en_data),
      .stat_rd(stat_rd), .cap_rd(cap_rd), .pwm_irq(pwm_irq), .brk_irq(brk_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] conds(input int n);
      logic [CW-1:0] c, p, q;
      logic [3:0] r;
      c = cnt_val[n*CW +: CW];
      p = per_val[n*CW +: CW];
      q = cmp_val[n*CW +: CW];
      r[0] = (c == 0);
      r[1] = (c == p);
      r[2] = (c == q) &&  cnt_up[n];
      r[3] = (c == q) && !cnt_up[n];
      return r;
   endfunction

   // model of one clock edge, from the requirements
   task automatic model_edge();
      logic [31:0] sset, sclr;
      logic [15:0] cset, cclr;
      logic [3:0]  cd;
      sset = '0; cset = '0;
      for (int n = 0; n < NCH; n++) begin
         cd = conds(n);
         for (int k = 0; k < 4; k++) sset[k*8+n] = cd[k] & ~m_prev[n][k];
         m_prev[n] = cd;
         cset[n]   = cap_rise[n];
         cset[8+n] = cap_fall[n];
      end
      sclr = stat_clr_we ? stat_clr_data : '0;
      cclr = cap_clr_we ? cap_clr_data : '0;
      m_irq = (|(m_stat & m_sen)) | (|(m_cap & m_cen));
      m_brk = brk_req;
      m_stat = ((m_stat & ~sclr) | sset) & SVALID;
      m_cap  = ((m_cap & ~cclr) | cset) & CVALID;
      if (stat_en_we) m_sen = stat_en_data & SVALID;
      if (cap_en_we)  m_cen = cap_en_data & CVALID;
   endtask

   task automatic tick();
      model_edge();
      @(posedge clk);
      #1;
      chk("R2/R3/R4/R5/R6/R7 status", stat_rd, m_stat);
      chk("R8/R7 capture", {16'h0, cap_rd}, {16'h0, m_cap});
      chk("R9/R10 irq", {31'h0, pwm_irq}, {31'h0, m_irq});
      chk("R11 brake", {31'h0, brk_irq}, {31'h0, m_brk});
      stat_clr_we = 0; cap_clr_we = 0; stat_en_we = 0; cap_en_we = 0;
      cap_rise = '0; cap_fall = '0;
   endtask

   task automatic set_cnt(input int n, input int v);
      cnt_val[n*CW +: CW] = CW'(v);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED1234));
      for (int n = 0; n < NCH; n++) begin
         m_prev[n] = '0;
         set_cnt(n, 1);
         per_val[n*CW +: CW] = CW'(6);
         cmp_val[n*CW +: CW] = CW'(3);
      end
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 status", stat_rd, 32'h0);
      chk("R1 capture", {16'h0, cap_rd}, 32'h0);
      chk("R1 irq", {31'h0, pwm_irq}, 32'h0);
      chk("R1 brake", {31'h0, brk_irq}, 32'h0);
      // model prev conds mirror the pre-reset-release register contents (0)
      rst_n = 1'b1;
      tick();

      // R2 / R6: dwell on zero, clear mid-dwell
      set_cnt(0, 0);
      tick();
      chk("R2 zero flag", stat_rd & 32'h1, 32'h1);
      tick(); tick();
      stat_clr_we = 1; stat_clr_data = 32'h1;
      tick();
      tick(); tick();
      chk("R6 no re-set while dwelling", stat_rd & 32'h1, 32'h0);
      // R7: re-arrival with simultaneous clear -> event wins
      set_cnt(0, 1);
      tick();
      set_cnt(0, 0);
      stat_clr_we = 1; stat_clr_data = 32'h1;
      tick();
      chk("R7 event beats clear", stat_rd & 32'h1, 32'h1);

      // R4 / R5: direction steering on channel 2
      cnt_up[2] = 1; set_cnt(2, 3);
      tick();
      chk("R4 up compare", stat_rd & 32'h0404_0000, 32'h0004_0000);
      set_cnt(2, 4); tick();
      cnt_up[2] = 0; set_cnt(2, 3);
      tick();
      chk("R5 down compare", stat_rd & 32'h0400_0000, 32'h0400_0000);
      // R3 period on channel 5
      set_cnt(5, 6);
      tick();
      chk("R3 period", stat_rd & 32'h0000_2000, 32'h0000_2000);

      // R9: disabled flags do not raise irq, enabled ones do
      tick();
      chk("R9 masked irq", {31'h0, pwm_irq}, 32'h0);
      // R12: enables in unused lanes have no effect
      stat_en_we = 1; stat_en_data = ~SVALID;
      tick(); tick();
      chk("R12 unused enable", {31'h0, pwm_irq}, 32'h0);
      chk("R12 unused status bits", stat_rd & ~SVALID, 32'h0);
      stat_en_we = 1; stat_en_data = 32'h0000_2000;
      tick(); tick();
      chk("R9 enabled irq", {31'h0, pwm_irq}, 32'h1);
      stat_clr_we = 1; stat_clr_data = 32'hFFFF_FFFF;
      stat_en_we = 1; stat_en_data = 32'h0;
      tick(); tick();
      chk("R9 irq drops", {31'h0, pwm_irq}, 32'h0);
      // R8 / R10: capture onto shared line
      cap_fall[4] = 1;
      cap_en_we = 1; cap_en_data = 16'h1000;
      tick();
      chk("R8 fall capture", {16'h0, cap_rd}, 32'h1000);
      tick();
      chk("R10 capture irq", {31'h0, pwm_irq}, 32'h1);
      // R11: brake independent of flags
      brk_req = 1; cap_clr_we = 1; cap_clr_data = 16'hFFFF;
      tick();
      chk("R11 brake passthrough", {31'h0, brk_irq}, 32'h1);
      brk_req = 0;
      tick();

      // random phase
      for (int i = 0; i < 4000; i++) begin
         for (int n = 0; n < NCH; n++) begin
            if (($urandom % 4) != 0) set_cnt(n, int'($urandom % 8));
            if (($urandom % 8) == 0) cnt_up[n] = ~cnt_up[n];
            if (($urandom % 64) == 0) cmp_val[n*CW +: CW] = CW'($urandom % 8);
         end
         cap_rise = NCH'($urandom) & NCH'($urandom);
         cap_fall = NCH'($urandom) & NCH'($urandom);
         brk_req  = ($urandom % 5) == 0;
         if (($urandom % 3) == 0) begin
            stat_clr_we = 1; stat_clr_data = $urandom;
         end
         if (($urandom % 3) == 0) begin
            cap_clr_we = 1; cap_clr_data = 16'($urandom);
         end
         if (($urandom % 40) == 0) begin
            stat_en_we = 1; stat_en_data = $urandom & $urandom;
         end
         if (($urandom % 40) == 0) begin
            cap_en_we = 1; cap_en_data = 16'($urandom & $urandom);
         end
         tick();
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule